// File: doc/BRIEF.md
# Packed SIMD Saturating Add/Subtract Unit

This block adds or subtracts two 64-bit packed operands lane by lane. A size select divides the word into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane is computed on its own: no carry or borrow ever crosses from one lane into the next. An operation select picks add or subtract. It applies to all lanes at once.

A mode select sets what happens when a lane's true result does not fit its width. Wrap keeps the low bits. Signed saturation clamps to the signed limits of the lane width. Unsigned saturation clamps to all-ones or to zero. Each byte of the result has an overflow flag. For wider lanes the flag is copied across every byte of the lane.

Operands and selects are taken on a clock edge where the valid strobe is high. The result, the flags and an output valid appear one cycle later.

Top module: `simd_addsub`

## Requirements
- R1: `size_sel` sets the lane width: 00 gives 8-bit lanes, 01 gives 16-bit lanes, 10 and 11 give 32-bit lanes. No lane's result depends on any bit of the other lanes.
- R2: With `op_sub`=0 each lane computes a+b. With `op_sub`=1 each lane computes a-b, with `src_a` as the minuend.
- R3: With `mode_sel`=00 (wrap), and also with the spare code 11, each lane holds the low lane-width bits of the true result.
- R4: With `mode_sel`=01 (signed saturation), a lane whose true signed result is above 2^(w-1)-1 yields 2^(w-1)-1. A lane whose result is below -2^(w-1) yields -2^(w-1) (0x80, 0x8000, 0x80000000).
- R5: With `mode_sel`=10 (unsigned saturation), a lane whose true unsigned result exceeds 2^w-1 yields all-ones. A lane whose result is below zero yields zero.
- R6: Bit k of `ovf_flags` belongs to byte k, which is `result[8k+7:8k]`. It is set when the lane holding byte k had a true result out of range. The range is unsigned in mode 10 and signed in modes 00, 01 and 11. All flag bits of one lane are equal.
- R7: When `in_valid` is high at a rising edge, `result` and `ovf_flags` show that input at the next edge and `out_valid` is high for that cycle. When `in_valid` is low, `out_valid` drops and `result` and `ovf_flags` hold their values.
- R8: While `rst_n` is low at a clock edge, `out_valid`, `result` and `ovf_flags` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for operands and selects |
| size_sel | input | 2 | Lane width select |
| mode_sel | input | 2 | Out-of-range handling select |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| src_a | input | 64 | Packed first operand |
| src_b | input | 64 | Packed second operand |
| out_valid | output | 1 | Result valid, one cycle after capture |
| result | output | 64 | Packed lane results |
| ovf_flags | output | 8 | Per-byte out-of-range flags |

## Verification
Lane isolation and clamping act in the same cycle when one lane overflows while its neighbour must not see the carry the overflow produces. The bench provokes this with operands where a lane near its limit sits next to a lane of zeros or ones. One example is a low 32-bit lane of 0xFFFFFFFF plus 1 under a zero upper lane, run in every mode. In each case both lanes are compared to a model that uses wider integers. The clamped or wrapped lane must match, and the neighbour must come out exact, with its flags clear.

// File: rtl/simd_pkg.sv
// Shared types for the packed add/subtract unit.
// Assumes: lanes are built from 8-bit slices; encodings fixed below.
package simd_pkg;
    localparam int unsigned SLICE_W = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_FULL = 2'b10,
        SZ_SPARE = 2'b11
    } elem_size_e;

    typedef enum logic [1:0] {
        OVF_WRAP  = 2'b00,
        OVF_SSAT  = 2'b01,
        OVF_USAT  = 2'b10,
        OVF_SPARE = 2'b11
    } ovf_mode_e;
endpackage

// File: rtl/simd_lane_map.sv
// Lane map: turns the size select into per-slice lane boundary marks.
// Assumes: slice count is a multiple of four; spare size code acts as 32-bit.
module simd_lane_map
    import simd_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 8
) (
    input  elem_size_e              size,
    output logic [1:0]              grp_mask,
    output logic [NUM_SLICES-1:0]   lane_first,
    output logic [NUM_SLICES-1:0]   lane_last
);
    // Slices per lane minus one, as a low-bit mask of the slice index.
    always_comb begin
        case (size)
            SZ_BYTE: grp_mask = 2'b00;
            SZ_HALF: grp_mask = 2'b01;
            default: grp_mask = 2'b11;
        endcase
    end

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_mark
        localparam logic [1:0] KPOS = 2'(k % 4);
        // Mark the lowest and highest slice of each lane.
        assign lane_first[k] = ((KPOS & grp_mask) == 2'b00);
        assign lane_last[k]  = ((KPOS & grp_mask) == grp_mask);
    end
endmodule

// File: rtl/simd_byte_slice.sv
// One 8-bit adder slice. Subtract inverts b; the carry in supplies the +1
// at a lane start, or the carry from the slice below inside a lane.
// Outputs the carry into the top bit so signed overflow can be formed.
module simd_byte_slice
    import simd_pkg::*;
(
    input  logic [SLICE_W-1:0] a,
    input  logic [SLICE_W-1:0] b,
    input  logic               op_sub,
    input  logic               cin,
    output logic [SLICE_W-1:0] sum,
    output logic               cout,
    output logic               c_msb
);
    logic [SLICE_W-1:0] b_eff;
    logic [SLICE_W-1:0] low_sum;

    // Conditional invert of the second operand for subtract.
    assign b_eff = b ^ {SLICE_W{op_sub}};

    // Low bits with carry into the top bit, then the top bit itself.
    always_comb begin
        low_sum = {1'b0, a[SLICE_W-2:0]} + {1'b0, b_eff[SLICE_W-2:0]} + {{(SLICE_W-1){1'b0}}, cin};
        c_msb   = low_sum[SLICE_W-1];
        {cout, sum[SLICE_W-1]} = {1'b0, a[SLICE_W-1]} + {1'b0, b_eff[SLICE_W-1]} + {1'b0, c_msb};
        sum[SLICE_W-2:0] = low_sum[SLICE_W-2:0];
    end
endmodule

// File: rtl/simd_byte_clamp.sv
// Per-byte result select: wrapped sum, or this byte's share of a clamp rail.
// Assumes: the lane-level clamp decision arrives already broadcast.
module simd_byte_clamp
    import simd_pkg::*;
(
    input  logic [SLICE_W-1:0] wrap_sum,
    input  logic               clamp_en,
    input  logic               clamp_high,
    input  logic               signed_rail,
    input  logic               is_top,
    output logic [SLICE_W-1:0] out_byte
);
    logic [SLICE_W-1:0] rail;

    // Rail byte: signed limits differ from all-ones/zero only in the top byte.
    always_comb begin
        if (clamp_high)
            rail = (signed_rail && is_top) ? {1'b0, {(SLICE_W-1){1'b1}}} : {SLICE_W{1'b1}};
        else
            rail = (signed_rail && is_top) ? {1'b1, {(SLICE_W-1){1'b0}}} : {SLICE_W{1'b0}};
    end

    // Final byte mux.
    assign out_byte = clamp_en ? rail : wrap_sum;
endmodule

// File: rtl/simd_addsub.sv
// Packed add/subtract with per-lane wrap or saturation and a one-cycle
// output register. One slice chain serves all lane sizes; carries are cut
// at lane starts. Assumes NUM_SLICES is a multiple of four.
module simd_addsub
    import simd_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [1:0]                      size_sel,
    input  logic [1:0]                      mode_sel,
    input  logic                            op_sub,
    input  logic [NUM_SLICES*SLICE_W-1:0]   src_a,
    input  logic [NUM_SLICES*SLICE_W-1:0]   src_b,
    output logic                            out_valid,
    output logic [NUM_SLICES*SLICE_W-1:0]   result,
    output logic [NUM_SLICES-1:0]           ovf_flags
);
    localparam int unsigned DATA_W = NUM_SLICES * SLICE_W;

    ovf_mode_e              mode;
    logic [1:0]             grp_mask;
    logic [NUM_SLICES-1:0]  lane_first, lane_last;
    logic [NUM_SLICES-1:0]  cin, cout, c_msb, a_msb;
    logic [NUM_SLICES-1:0]  s_ovf, u_ovf;
    logic [NUM_SLICES-1:0]  lane_sovf, lane_uovf, lane_asgn;
    logic [NUM_SLICES-1:0]  clamp_en, clamp_high, flag_nxt;
    logic [DATA_W-1:0]      wrap_sum, res_nxt;

    assign mode = ovf_mode_e'(mode_sel);

    simd_lane_map #(.NUM_SLICES(NUM_SLICES)) u_map (
        .size       (elem_size_e'(size_sel)),
        .grp_mask   (grp_mask),
        .lane_first (lane_first),
        .lane_last  (lane_last)
    );

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
        // Carry in: subtract's +1 at a lane start, chained carry inside a lane.
        if (k == 0) begin : g_base
            assign cin[k] = op_sub;
        end else begin : g_chain
            assign cin[k] = lane_first[k] ? op_sub : cout[k-1];
        end

        simd_byte_slice u_slice (
            .a      (src_a[k*SLICE_W +: SLICE_W]),
            .b      (src_b[k*SLICE_W +: SLICE_W]),
            .op_sub (op_sub),
            .cin    (cin[k]),
            .sum    (wrap_sum[k*SLICE_W +: SLICE_W]),
            .cout   (cout[k]),
            .c_msb  (c_msb[k])
        );

        // Overflow as seen if this slice were the top of its lane.
        assign s_ovf[k] = c_msb[k] ^ cout[k];
        assign u_ovf[k] = cout[k] ^ op_sub;
        assign a_msb[k] = src_a[k*SLICE_W + SLICE_W - 1];

        simd_byte_clamp u_clamp (
            .wrap_sum    (wrap_sum[k*SLICE_W +: SLICE_W]),
            .clamp_en    (clamp_en[k]),
            .clamp_high  (clamp_high[k]),
            .signed_rail (mode == OVF_SSAT),
            .is_top      (lane_last[k]),
            .out_byte    (res_nxt[k*SLICE_W +: SLICE_W])
        );
    end

    // Index of the top slice of the lane holding slice k.
    function automatic int unsigned lane_top(input int unsigned k, input logic [1:0] m);
        return k | {30'b0, m};
    endfunction

    // Broadcast top-slice overflow and operand sign across each lane.
    always_comb begin
        for (int unsigned k = 0; k < NUM_SLICES; k++) begin
            lane_sovf[k] = s_ovf[lane_top(k, grp_mask)];
            lane_uovf[k] = u_ovf[lane_top(k, grp_mask)];
            lane_asgn[k] = a_msb[lane_top(k, grp_mask)];
        end
    end

    // Clamp decision, rail direction and flag per slice.
    always_comb begin
        for (int unsigned k = 0; k < NUM_SLICES; k++) begin
            case (mode)
                OVF_SSAT: begin
                    clamp_en[k]   = lane_sovf[k];
                    clamp_high[k] = ~lane_asgn[k];
                    flag_nxt[k]   = lane_sovf[k];
                end
                OVF_USAT: begin
                    clamp_en[k]   = lane_uovf[k];
                    clamp_high[k] = ~op_sub;
                    flag_nxt[k]   = lane_uovf[k];
                end
                default: begin
                    clamp_en[k]   = 1'b0;
                    clamp_high[k] = 1'b0;
                    flag_nxt[k]   = lane_sovf[k];
                end
            endcase
        end
    end

    // Output register: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            ovf_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= res_nxt;
                ovf_flags <= flag_nxt;
            end
        end
    end
endmodule

// File: rtl/simd_addsub_chk.sv
// Property checker for simd_addsub, attached by bind below.
// Assumes the port encodings stated in the brief.
module simd_addsub_chk
    import simd_pkg::*;
#(
    parameter int unsigned NUM_SLICES = 8
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          in_valid,
    input logic [1:0]                    size_sel,
    input logic [1:0]                    mode_sel,
    input logic                          out_valid,
    input logic [NUM_SLICES*SLICE_W-1:0] result,
    input logic [NUM_SLICES-1:0]         ovf_flags
);
    p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(ovf_flags)));

    for (genvar j = 0; j < NUM_SLICES / 2; j++) begin : g_half
        p_flag_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(size_sel) == 2'b01) |-> (ovf_flags[2*j] == ovf_flags[2*j+1]));
    end

    for (genvar j = 0; j < NUM_SLICES / 4; j++) begin : g_full
        p_flag_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(size_sel[1])) |->
            (ovf_flags[4*j +: 4] == 4'h0 || ovf_flags[4*j +: 4] == 4'hF));
    end

    for (genvar k = 0; k < NUM_SLICES; k++) begin : g_rail
        p_usat_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(mode_sel) == 2'b10 && ovf_flags[k]) |->
            (result[k*SLICE_W +: SLICE_W] == 8'hFF || result[k*SLICE_W +: SLICE_W] == 8'h00));

        p_ssat_rail_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(mode_sel) == 2'b01 && $past(size_sel) == 2'b00 && ovf_flags[k]) |->
            (result[k*SLICE_W +: SLICE_W] == 8'h7F || result[k*SLICE_W +: SLICE_W] == 8'h80));
    end
endmodule

bind simd_addsub simd_addsub_chk #(.NUM_SLICES(NUM_SLICES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .mode_sel  (mode_sel),
    .out_valid (out_valid),
    .result    (result),
    .ovf_flags (ovf_flags)
);

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  size_sel, mode_sel;
    logic        op_sub;
    logic [63:0] src_a, src_b;
    logic        out_valid;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    simd_addsub u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .size_sel (size_sel), .mode_sel (mode_sel), .op_sub (op_sub),
        .src_a (src_a), .src_b (src_b),
        .out_valid (out_valid), .result (result), .ovf_flags (ovf_flags)
    );

    localparam int NVEC = 10;
    localparam logic [63:0] TAB_A [NVEC] = '{
        64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7F7F_7F7F_7F7F_7F7F,
        64'h8080_8080_8080_8080, 64'h0123_4567_89AB_CDEF, 64'h7FFF_8000_7FFF_8000,
        64'h8000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'hFF00_FF00_00FF_00FF,
        64'h0001_FFFE_8001_7FFE };
    localparam logic [63:0] TAB_B [NVEC] = '{
        64'h0000_0000_0000_0001, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101,
        64'h7F01_80FF_0102_FE03, 64'hFEDC_BA98_7654_3210, 64'h0001_FFFF_8000_0001,
        64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 64'h00FF_FF01_FF01_0001,
        64'hFFFF_0003_8000_FFFF };

    // Lane-by-lane model in wide integers.
    function automatic void ref_model(input logic [63:0] a, input logic [63:0] b,
                                      input logic [1:0] sz, input logic [1:0] md,
                                      input logic op,
                                      output logic [63:0] r, output logic [7:0] f);
        int lb, w;
        longint ua, ub, sa, sb, tu, ts, hi, lo;
        logic [63:0] m, v;
        logic ovu, ovs, fl;
        lb = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        w  = lb * 8;
        m  = (64'd1 << w) - 64'd1;
        hi = (longint'(1) << (w - 1)) - 1;
        lo = -(longint'(1) << (w - 1));
        r = '0;
        f = '0;
        for (int l = 0; l < 8 / lb; l++) begin
            ua = longint'((a >> (l * w)) & m);
            ub = longint'((b >> (l * w)) & m);
            sa = (((ua >> (w - 1)) & 1) != 0) ? ua - (longint'(1) << w) : ua;
            sb = (((ub >> (w - 1)) & 1) != 0) ? ub - (longint'(1) << w) : ub;
            tu = op ? ua - ub : ua + ub;
            ts = op ? sa - sb : sa + sb;
            ovu = (tu < 0) || (tu > longint'(m));
            ovs = (ts > hi) || (ts < lo);
            v = 64'(tu) & m;
            if (md == 2'b01 && ovs) v = (ts > hi) ? (64'(hi) & m) : (64'(lo) & m);
            else if (md == 2'b10 && ovu) v = (tu < 0) ? 64'd0 : m;
            r = r | (v << (l * w));
            fl = (md == 2'b10) ? ovu : ovs;
            if (fl) f = f | 8'(((1 << lb) - 1) << (l * lb));
        end
    endfunction

    task automatic check(input string req, input logic [63:0] got_r, input logic [7:0] got_f,
                         input logic [63:0] exp_r, input logic [7:0] exp_f);
        n_checks++;
        if (got_r !== exp_r || got_f !== exp_f) begin
            n_fails++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, got_r, got_f, exp_r, exp_f);
        end
    endtask

    // Drive one operation and sample the registered outputs one cycle later.
    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                          input logic [1:0] md, input logic op,
                          output logic [63:0] r, output logic [7:0] f, output logic v);
        @(negedge clk);
        src_a = a; src_b = b; size_sel = sz; mode_sel = md; op_sub = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        r = result; f = ovf_flags; v = out_valid;
    endtask

    function automatic string mode_req(input logic [1:0] md);
        return (md == 2'b01) ? "R4/R6" : (md == 2'b10) ? "R5/R6" : "R3/R6";
    endfunction

    initial begin
        logic [63:0] r, er;
        logic [7:0]  f, ef;
        logic        v;
        rst_n = 1'b0; in_valid = 1'b0; size_sel = '0; mode_sel = '0; op_sub = 1'b0;
        src_a = 64'hDEAD_BEEF_0BAD_F00D; src_b = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8", result, ovf_flags, 64'd0, 8'd0);
        check("R8 valid", {63'd0, out_valid}, 8'd0, 64'd0, 8'd0);
        rst_n = 1'b1;

        // Table walk over every size, mode and operation (R1, R2 with mode tags).
        for (int i = 0; i < NVEC; i++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int md = 0; md < 3; md++) begin
                    for (int op = 0; op < 2; op++) begin
                        run_op(TAB_A[i], TAB_B[i], 2'(sz), 2'(md), 1'(op), r, f, v);
                        ref_model(TAB_A[i], TAB_B[i], 2'(sz), 2'(md), 1'(op), er, ef);
                        check({"R1/R2/", mode_req(2'(md))}, r, f, er, ef);
                    end
                end
            end
        end

        // R4: byte positive and negative overflow clamp.
        run_op(64'h0000_0000_0000_807F, 64'h0000_0000_0000_FF01, 2'b00, 2'b01, 1'b0, r, f, v);
        check("R4 byte clamp", r, f, 64'h0000_0000_0000_807F, 8'b0000_0011);
        // R3: same operands wrap.
        run_op(64'h0000_0000_0000_807F, 64'h0000_0000_0000_FF01, 2'b00, 2'b00, 1'b0, r, f, v);
        check("R3 byte wrap", r, f, 64'h0000_0000_0000_7F80, 8'b0000_0011);
        // R5: unsigned underflow to zero on subtract.
        run_op(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'b01, 2'b10, 1'b1, r, f, v);
        check("R5 half underflow", r, f, 64'h0000_0000_0000_0000, 8'b0000_0011);
        // R2: word subtract with signed clamp to most negative.
        run_op(64'h0000_0000_0000_8000, 64'h0000_0000_0000_0001, 2'b01, 2'b01, 1'b1, r, f, v);
        check("R2 sub clamp", r, f, 64'h0000_0000_0000_8000, 8'b0000_0011);
        // R1: carry isolation at the 32-bit boundary in every mode.
        run_op(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 2'b00, 1'b0, r, f, v);
        check("R1 full wrap isolation", r, f, 64'h0000_0000_0000_0000, 8'h00);
        run_op(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'b10, 2'b10, 1'b0, r, f, v);
        check("R1 full usat isolation", r, f, 64'h0000_0000_FFFF_FFFF, 8'h0F);
        run_op(64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001, 2'b11, 2'b01, 1'b0, r, f, v);
        check("R1 spare size as full", r, f, 64'h0000_0000_7FFF_FFFF, 8'h0F);
        // R3: spare mode code acts as wrap.
        run_op(TAB_A[5], TAB_B[5], 2'b01, 2'b11, 1'b0, r, f, v);
        ref_model(TAB_A[5], TAB_B[5], 2'b01, 2'b00, 1'b0, er, ef);
        check("R3 spare mode", r, f, er, ef);

        // R7: valid pulse and hold while strobe is low.
        run_op(64'h1111_2222_3333_4444, 64'h0101_0101_0101_0101, 2'b00, 2'b00, 1'b0, r, f, v);
        check("R7 out_valid high", {63'd0, v}, 8'd0, 64'd1, 8'd0);
        src_a = 64'hFFFF_FFFF_FFFF_FFFF; src_b = 64'hFFFF_FFFF_FFFF_FFFF; mode_sel = 2'b10;
        repeat (2) @(negedge clk);
        check("R7 hold", result, ovf_flags, 64'h1212_2323_3434_4545, 8'h00);
        check("R7 out_valid low", {63'd0, out_valid}, 8'd0, 64'd0, 8'd0);

        // R8: reset mid-stream clears outputs.
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 rerun", result, ovf_flags, 64'd0, 8'd0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule